// File: doc/BRIEF.md
# Table-Selected Reference Clock Divider

This block divides a reference clock by one of eight fixed ratios. A 3-bit selection code indexes a small decode table that yields a 14-bit divide value. The value minus one is loaded into a down-counter. Each time the counter reaches zero it reloads and emits a one-clock pulse, so the pulse train runs at the reference rate divided by the selected ratio. The pulse drives the reference side of a phase detector in a frequency synthesizer.

The selection code is read only at a reload. A code change therefore never shortens or stretches the divide cycle already in progress. Board-level selection inputs that are left open are expected to read as 1. That gives code 111, which is the slowest ratio.

Top module: `refdiv_top`

## Requirements
- R1: The selection code maps to a divide value D as follows: 000 gives 8, 001 gives 128, 010 gives 256, 011 gives 512, 100 gives 1024, 101 gives 2048, 110 gives 2410, and 111 gives 8192. 111 is the code seen when all inputs are left open.
- R2: Every output pulse is high for exactly one clock cycle.
- R3: Consecutive rising edges of the output are exactly D clock cycles apart, where D is the divide value for the held code.
- R4: While reset is asserted the output is low. After reset is released, the first rising clock edge loads the counter, and the output first goes high after rising edge D+1.
- R5: The interval that ends at a pulse equals the D of the code sampled at the edge that raised the previous pulse. A code change made between pulses first affects the interval that starts at the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Divide ratio selection code |
| ref_pulse_o | output | 1 | Divided-rate pulse, one clock wide |

## Verification
The output is registered. After reset release the first pulse is due after rising edge D+1. After that, a pulse is due every D edges. A selection change is counted from the pulse that follows the edge at which the change is sampled. The bench changes inputs and samples the output on falling edges. It counts falling edges between the samples that show the pulse high. This makes every measured interval an exact count of rising edges, and no check depends on process ordering at an edge. For the R5 case, the bench changes the code on the falling edge right after a pulse. It then expects the old ratio for one more interval and the new ratio after that.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned CNT_W = 14;
endpackage

// File: rtl/refdiv_rom.sv
module refdiv_rom
  import refdiv_pkg::*;
#(
  parameter int unsigned DW = CNT_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [DW-1:0]    div_o
);
  always_comb begin
    unique case (sel_i)
      3'd0:    div_o = DW'(8);
      3'd1:    div_o = DW'(128);
      3'd2:    div_o = DW'(256);
      3'd3:    div_o = DW'(512);
      3'd4:    div_o = DW'(1024);
      3'd5:    div_o = DW'(2048);
      3'd6:    div_o = DW'(2410);
      default: div_o = DW'(8192);
    endcase
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int unsigned DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] reload_i,
  output logic [DW-1:0] cnt_o,
  output logic          run_o,
  output logic          pulse_o
);
  logic tc;
  assign tc = (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      run_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else if (!run_o) begin
      // first edge after reset: load only, no pulse
      cnt_o   <= reload_i;
      run_o   <= 1'b1;
      pulse_o <= 1'b0;
    end else if (tc) begin
      cnt_o   <= reload_i;
      pulse_o <= 1'b1;
    end else begin
      cnt_o   <= cnt_o - 1'b1;
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned DW = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ref_pulse_o
);
  logic [DW-1:0] div_val;
  logic [DW-1:0] reload;
  logic [DW-1:0] cnt;
  logic          run;

  refdiv_rom #(.DW(DW)) rom_i (
    .sel_i (sel_i),
    .div_o (div_val)
  );

  assign reload = div_val - 1'b1;

  refdiv_counter #(.DW(DW)) cnt_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .cnt_o    (cnt),
    .run_o    (run),
    .pulse_o  (ref_pulse_o)
  );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
  import refdiv_pkg::*;
#(
  parameter int unsigned DW = CNT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic [DW-1:0]    div_val_i,
  input logic [DW-1:0]    cnt_i,
  input logic             run_i,
  input logic             pulse_i
);
  logic [DW:0]   gap_q;
  logic [DW-1:0] nxt_q, per_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      nxt_q  <= '0;
      per_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (run_i && cnt_i == '0) nxt_q <= div_val_i;
      if (pulse_i) begin
        gap_q  <= (DW+1)'(1);
        per_q  <= nxt_q;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  odd_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == 3'd6 |-> div_val_i == DW'(2410));

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !pulse_i);

  // R3
  period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && seen_q) |-> gap_q == {1'b0, per_q});

  // R4
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pulse_i);

  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == '0) |=> (cnt_i == $past(div_val_i) - 1'b1) && pulse_i);

  // R3
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i != '0) |=> cnt_i == $past(cnt_i) - 1'b1);
endmodule

bind refdiv_top refdiv_chk #(.DW(DW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .div_val_i (div_val),
  .cnt_i     (cnt),
  .run_i     (run),
  .pulse_i   (ref_pulse_o)
);

// File: tb/refdiv_top_tb_top.sv
module refdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b111; // open inputs read as 1
  logic       pulse;
  int         errors = 0;
  int         checks = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  refdiv_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sel_i       (sel),
    .ref_pulse_o (pulse)
  );

  function automatic int exp_div(input logic [2:0] c);
    case (c)
      3'd0: return 8;     3'd1: return 128;
      3'd2: return 256;   3'd3: return 512;
      3'd4: return 1024;  3'd5: return 2048;
      3'd6: return 2410;  default: return 8192;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!pulse);
  endtask

  // returns falling edges until next high sample; checks width on first
  task automatic measure(input string req, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) check("R2", int'(pulse), 0);
    end while (!pulse && n < 20000);
  endtask

  task automatic test_reset_first();
    int n;
    rst_n = 1'b0;
    sel = 3'd0;
    repeat (3) @(negedge clk);
    check("R4 reset low", int'(pulse), 0);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse && n < 100);
    check("R4 first pulse edge", n, exp_div(3'd0) + 1);
  endtask

  task automatic test_code(input logic [2:0] c);
    int n;
    sel = c;
    wait_pulse();
    wait_pulse(); // interval after this pulse uses c
    measure("R3", n);
    check($sformatf("R1/R3 code %0d", c), n, exp_div(c));
  endtask

  task automatic test_switch();
    int n;
    sel = 3'd0;
    wait_pulse();
    wait_pulse();
    sel = 3'd1; // sampled after the reload that raised this pulse
    measure("R5", n);
    check("R5 old ratio kept", n, 8);
    measure("R5", n);
    check("R5 new ratio", n, 128);
    sel = 3'd2;
    repeat (5) @(negedge clk);
    sel = 3'd0; // mid-interval bounce, not sampled at a reload
    wait_pulse();
    measure("R5", n);
    check("R5 bounce ignored", n, 8);
  endtask

  initial begin
    test_reset_first();
    for (int c = 0; c < 8; c++) test_code(3'(c));
    test_code(3'd6);
    test_switch();
    test_code(3'b111); // open-input default
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule